// File: doc/BRIEF.md
# Calibration Clock Divider and Start Trigger

This block sits beside a frequency synthesizer's calibration engine. It divides the reference clock by a selectable power of two to form a slow calibration clock. It also turns a software-controlled calibrate bit into a single start pulse. The calibrate bit and the divider select are written into a shadow stage that the logic does not see. Both move into an active stage only when an update strobe is applied.

A calibration starts only when the active calibrate bit rises from 0 to 1 through an update, and only if the reference is reported present. The correct sequence is: confirm the reference, write 0 and update, then write 1 and update. A start produces a one-cycle pulse and a busy flag. The busy flag stays high for a fixed number of whole calibration-clock periods, and the divider restarts at the start so that this count is exact.

Top module: `cal_kick_ctrl`

## Requirements
- R1: After reset, cal_start, cal_busy and cal_clk are 0, the active calibrate bit is 0, and the active divider select is 2'b11, so the ratio is 16.
- R2: The active select picks the cal_clk period in reference cycles: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 16. cal_clk is high for exactly half of each period.
- R3: Changes on cal_bit_shadow or div_sel_shadow have no effect on any output until upd_stb is sampled high.
- R4: If upd_stb is sampled high with cal_bit_shadow=1 while the active bit is 0 and ref_ok is 1, cal_start is high for exactly one reference cycle. That cycle is the one after the sampling edge.
- R5: If the active bit is already 1, an update with cal_bit_shadow=1 produces no start pulse.
- R6: If ref_ok is 0 at a 0-to-1 update, no start pulse is produced. The active bit still becomes 1, so a further start needs another 0 update followed by a 1 update.
- R7: cal_busy rises together with cal_start and stays high for BUSY_PERIODS × ratio reference cycles, where BUSY_PERIODS defaults to 4.
- R8: An update that changes the active select restarts the divider. cal_clk is 0 in the cycle after the update edge, and its first rise comes ratio/2 cycles after that edge. A start pulse restarts the divider in the same way.
- R9: A qualified 0-to-1 update that arrives while cal_busy is high produces no start pulse and does not change when busy ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_bit_shadow | input | 1 | Shadow copy of the calibrate bit |
| div_sel_shadow | input | 2 | Shadow divider select |
| upd_stb | input | 1 | Update strobe that copies shadow to active |
| ref_ok | input | 1 | Reference-present flag |
| cal_clk | output | 1 | Divided calibration clock |
| cal_start | output | 1 | One-cycle calibration start pulse |
| cal_busy | output | 1 | High while calibration runs |

## Verification
The bench repeats the update with a 1 while the active bit is already 1. A design that detects a level instead of an edge would fire again here. It also performs a 0-to-1 update while ref_ok is low and then repeats the 1. A design that still fires, or that remembers the missed edge and fires on the repeat, is reported. It measures the period and high time of cal_clk at every select, and the delay to the first rise after a select change. A divider that does not restart, or that reads the select straight from the shadow stage, shows the wrong count. It also measures busy length at two ratios while a second qualified edge arrives mid-run. A design that re-arms or extends busy on that edge is caught.

// File: rtl/cal_kick_pkg.sv
package cal_kick_pkg;
    localparam int SEL_W    = 2;
    localparam int MAX_HALF = 1 << ((1 << SEL_W) - 1);
    localparam int CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

    typedef logic [SEL_W-1:0] div_sel_t;

    localparam div_sel_t SEL_RESET = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             clk;
    } div_state_t;

    typedef struct packed {
        logic     act_bit;
        div_sel_t act_sel;
        logic     start;
    } trig_state_t;
endpackage

// File: rtl/cal_trigger.sv
module cal_trigger
    import cal_kick_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_shadow,
    input  div_sel_t sel_shadow,
    input  logic     upd,
    input  logic     ref_ok,
    input  logic     busy,
    output div_sel_t act_sel,
    output logic     kick,
    output logic     sel_change,
    output logic     start_pulse
);
    trig_state_t st_d, st_q;
    logic        rising;

    always_comb begin
        st_d       = st_q;
        rising     = upd && bit_shadow && !st_q.act_bit;
        kick       = rising && ref_ok && !busy;
        sel_change = upd && (sel_shadow != st_q.act_sel);
        st_d.start = kick;
        if (upd) begin
            st_d.act_bit = bit_shadow;
            st_d.act_sel = sel_shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.act_bit <= 1'b0;
            st_q.act_sel <= SEL_RESET;
            st_q.start   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_sel     = st_q.act_sel;
    assign start_pulse = st_q.start;

    // R3
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(st_q.act_bit) && $stable(st_q.act_sel)));

    // R5
    no_restart_when_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && st_q.act_bit) |=> !st_q.start);

    // R6
    needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |-> ($past(upd) && $past(ref_ok)));
endmodule

// File: rtl/cal_clk_div.sv
module cal_clk_div
    import cal_kick_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  div_sel_t sel,
    output logic     div_clk,
    output logic     period_end
);
    div_state_t       st_d, st_q;
    logic [CNT_W-1:0] half_m1;
    logic             toggle;

    always_comb begin
        st_d       = st_q;
        half_m1    = CNT_W'((1 << sel) - 1);
        toggle     = (st_q.cnt == half_m1);
        period_end = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
            st_d.clk = 1'b0;
        end else if (toggle) begin
            st_d.cnt   = '0;
            st_d.clk   = !st_q.clk;
            period_end = st_q.clk;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.clk <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_clk = st_q.clk;

    // R8
    restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !div_clk);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= half_m1 || $past(restart) || $past(st_q.cnt) > st_q.cnt || $changed(sel));
endmodule

// File: rtl/cal_busy_timer.sv
module cal_busy_timer #(
    parameter int BUSY_PERIODS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic period_end,
    output logic busy
);
    localparam int BW = $clog2(BUSY_PERIODS + 1);
    localparam logic [BW-1:0] LAST = BW'(BUSY_PERIODS - 1);

    typedef struct packed {
        logic          busy;
        logic [BW-1:0] cnt;
    } busy_state_t;

    busy_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.busy && period_end) begin
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;

    // R7
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R7
    busy_ends_on_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(period_end));
endmodule

// File: rtl/cal_kick_ctrl.sv
module cal_kick_ctrl
    import cal_kick_pkg::*;
#(
    parameter int BUSY_PERIODS = 4
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             cal_bit_shadow,
    input  logic [SEL_W-1:0] div_sel_shadow,
    input  logic             upd_stb,
    input  logic             ref_ok,
    output logic             cal_clk,
    output logic             cal_start,
    output logic             cal_busy
);
    div_sel_t act_sel;
    logic     kick;
    logic     sel_change;
    logic     period_end;
    logic     div_restart;

    cal_trigger u_trig (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .bit_shadow  (cal_bit_shadow),
        .sel_shadow  (div_sel_shadow),
        .upd         (upd_stb),
        .ref_ok      (ref_ok),
        .busy        (cal_busy),
        .act_sel     (act_sel),
        .kick        (kick),
        .sel_change  (sel_change),
        .start_pulse (cal_start)
    );

    assign div_restart = sel_change || kick;

    cal_clk_div u_div (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .restart    (div_restart),
        .sel        (act_sel),
        .div_clk    (cal_clk),
        .period_end (period_end)
    );

    cal_busy_timer #(.BUSY_PERIODS(BUSY_PERIODS)) u_busy (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .start      (kick),
        .period_end (period_end),
        .busy       (cal_busy)
    );

    // R4
    start_one_cycle_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        cal_start |=> !cal_start);

    // R7
    start_sets_busy_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        cal_start |-> (cal_busy && $rose(cal_busy)));

    // R9
    no_start_while_busy_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (cal_busy && upd_stb) |=> !cal_start);
endmodule

// File: tb/cal_kick_ctrl_tb.sv
module cal_kick_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BUSYP      = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cal_bit_shadow;
    logic [1:0] div_sel_shadow;
    logic       upd_stb;
    logic       ref_ok;
    logic       cal_clk;
    logic       cal_start;
    logic       cal_busy;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_kick_ctrl #(.BUSY_PERIODS(BUSYP)) dut_i (
        .clk_ref        (clk_ref_w),
        .rst_n          (rst_n),
        .cal_bit_shadow (cal_bit_shadow),
        .div_sel_shadow (div_sel_shadow),
        .upd_stb        (upd_stb),
        .ref_ok         (ref_ok),
        .cal_clk        (cal_clk),
        .cal_start      (cal_start),
        .cal_busy       (cal_busy)
    );
    wire clk_ref_w = clk;

    // vector: {cal bit, select[1:0], ref_ok, expected start}
    localparam int NV = 10;
    localparam logic [4:0] VEC [NV] = '{
        5'b0_11_1_0,  // R4 write 0, active already 0
        5'b1_11_1_1,  // R4 valid 0->1 start
        5'b1_11_1_0,  // R5 repeated 1
        5'b0_11_1_0,  // R4 back to 0
        5'b1_11_0_0,  // R6 reference missing
        5'b1_11_1_0,  // R6 missed edge not remembered
        5'b0_00_1_0,  // R4 back to 0
        5'b1_00_1_1,  // R4 start at ratio 2
        5'b0_10_1_0,  // R4 back to 0
        5'b1_10_1_1   // R4 start at ratio 8
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drives one update; returns at the negedge after the sampling edge
    task automatic do_upd(input logic b, input logic [1:0] s, input logic r);
        @(negedge clk);
        cal_bit_shadow = b;
        div_sel_shadow = s;
        ref_ok         = r;
        upd_stb        = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(output int per, output int hi);
        logic p;
        logic rise;
        p = cal_clk;
        do begin
            @(negedge clk);
            rise = cal_clk && !p;
            p = cal_clk;
        end while (!rise);
        per = 0;
        hi  = 0;
        do begin
            if (cal_clk) hi++;
            @(negedge clk);
            per++;
            rise = cal_clk && !p;
            p = cal_clk;
        end while (!rise);
    endtask

    initial begin
        int n;
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int per;
        int hi;
        int n;
        int seen;
        rst_n          = 1'b0;
        cal_bit_shadow = 1'b0;
        div_sel_shadow = 2'b11;
        upd_stb        = 1'b0;
        ref_ok         = 1'b1;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 start", cal_start, 0);
        chk("R1 busy", cal_busy, 0);
        chk("R1 clk", cal_clk, 0);
        measure(per, hi);
        chk("R1 default period", per, 16);

        // R3 shadow changes without strobe
        div_sel_shadow = 2'b00;
        cal_bit_shadow = 1'b1;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cal_start || cal_busy) seen++;
        end
        chk("R3 no start without strobe", seen, 0);
        measure(per, hi);
        chk("R3 period unchanged", per, 16);

        // vector table: R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            do_upd(VEC[v][4], VEC[v][3:2], VEC[v][1]);
            chk($sformatf("R4/R5/R6 vec%0d start", v), cal_start, VEC[v][0]);
            @(negedge clk);
            chk($sformatf("R4 vec%0d pulse width", v), cal_start, 0);
            idle(80);
        end
        ref_ok = 1'b1;

        // R2 period and duty at every select
        for (int s = 0; s < 4; s++) begin
            do_upd(1'b0, 2'(s), 1'b1);
            measure(per, hi);
            chk($sformatf("R2 period sel%0d", s), per, 2 << s);
            chk($sformatf("R2 high sel%0d", s), hi, 1 << s);
        end

        // R8 restart on select change (3 -> 2)
        do_upd(1'b0, 2'b10, 1'b1);
        chk("R8 low after change", cal_clk, 0);
        n = 0;
        do begin @(negedge clk); n++; end while (!cal_clk && n < 40);
        chk("R8 first rise", n, 4);

        // R7 busy length at ratio 16
        do_upd(1'b0, 2'b11, 1'b1);
        idle(20);
        do_upd(1'b1, 2'b11, 1'b1);
        chk("R7 start", cal_start, 1);
        chk("R7 busy with start", cal_busy, 1);
        chk("R8 low after start", cal_clk, 0);
        n = 1;
        forever begin
            @(negedge clk);
            if (!cal_busy || n > 200) break;
            n++;
        end
        chk("R7 busy length ratio16", n, BUSYP * 16);

        // R9 qualified edge during busy at ratio 4
        do_upd(1'b0, 2'b01, 1'b1);
        idle(10);
        do_upd(1'b1, 2'b01, 1'b1);
        chk("R9 initial start", cal_start, 1);
        n = 1;
        seen = 0;
        for (int j = 1; j < 200; j++) begin
            if (j == 2) begin cal_bit_shadow = 1'b0; upd_stb = 1'b1; end
            if (j == 3) upd_stb = 1'b0;
            if (j == 5) begin cal_bit_shadow = 1'b1; upd_stb = 1'b1; end
            if (j == 6) upd_stb = 1'b0;
            @(negedge clk);
            if (cal_start) seen++;
            if (!cal_busy) break;
            n++;
        end
        chk("R9 no start while busy", seen, 0);
        chk("R7 R9 busy length ratio4", n, BUSYP * 4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule